// File: doc/BRIEF.md
# Per-Channel Timed Vector Formatter

This block shapes the drive waveform of one tester channel from a stream of test vectors. It runs on a fine timing tick. A fixed number of ticks makes one vector period, so each tick stands for one step of edge resolution. With the defaults, the tick is 1 ns and a period is 10 ticks, which gives a 100 MHz vector rate at 1 ns edge placement.

Each vector carries a data bit and an index into a small table of time sets. The chosen time set gives three things: the tick at which the data is driven, the tick at which a return-to-zero pulse ends, and a flag that picks return-to-zero shaping over non-return-to-zero. The edge positions come from the table for every vector, so they can sit on any tick of the period and can change from one vector to the next. A setup or hold sweep therefore needs only a run of vectors that select time sets with stepped offsets.

Every instance holds its own table and its own period counter. Several channels are built by instantiating the block several times, and the timing of one channel never depends on another. The table is written through a plain address, data and write-enable port.

Top module: `tvf_channel_formatter`

## Requirements
- R1: After reset `pin_out` is 0 and every time-set entry is zero, so a vector that selects an entry never written is driven at tick 0 in non-return-to-zero form.
- R2: `vec_ready` is high only during the last tick of each period (tick count PERIOD_TICKS-1). It is high exactly once every PERIOD_TICKS clocks, and a vector is taken at that clock edge.
- R3: When the format flag is 0, `pin_out` takes the vector's data bit from the clock after tick `drv` and holds it to the next drive edge. Tick numbering restarts at 0 on the first clock after acceptance.
- R4: When the format flag is 1 and `ret` > `drv`, `pin_out` takes the data bit after tick `drv` and returns to 0 after tick `ret`.
- R5: When the format flag is 1 and `ret` <= `drv`, the return is suppressed and the vector behaves as in R3.
- R6: In a period for which no vector was accepted, `pin_out` holds its last level.
- R7: Each vector uses the time set named by its own `vec_sel`, so successive vectors can place their edges at different ticks.
- R8: A drive offset of PERIOD_TICKS or more never fires, so `pin_out` keeps its previous level for that vector.
- R9: The time set is captured when the vector is accepted. A write to that entry while the vector is running does not change that vector's edges, but it does apply to later vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fine timing tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Time-set write strobe |
| prog_addr | input | $clog2(NUM_SETS) | Time-set entry to write |
| prog_drv | input | 4 | Drive edge offset in ticks |
| prog_ret | input | 4 | Return edge offset in ticks |
| prog_rz | input | 1 | Format flag: 1 return-to-zero, 0 non-return-to-zero |
| vec_valid | input | 1 | A vector is offered |
| vec_ready | output | 1 | Vector is taken at this edge (last tick of period) |
| vec_data | input | 1 | Data bit of the offered vector |
| vec_sel | input | $clog2(NUM_SETS) | Time-set index of the offered vector |
| pin_out | output | 1 | Formatted drive level |

## Verification
The assertions assume three things about the inputs: reset is applied before the first vector, `vec_valid` is only treated as meaningful in the cycle where `vec_ready` is high, and the programming inputs are steady around the clock edge. The stimulus meets these by changing every input on the falling clock edge. It offers a vector only after it has seen `vec_ready` high, and it drops `vec_valid` right after the accepting edge. Edge offsets of PERIOD_TICKS or more are used on purpose, to show that such an edge never fires.

// File: rtl/tvf_pkg.sv
package tvf_pkg;
   localparam int unsigned OFS_W = 4;

   typedef struct packed {
      logic             rz;
      logic [OFS_W-1:0] ret;
      logic [OFS_W-1:0] drv;
   } tset_t;
endpackage

// File: rtl/tvf_timeset_rf.sv
module tvf_timeset_rf
   import tvf_pkg::*;
#(
   parameter int unsigned NUM_SETS   = 8,
   parameter bit          RZ_SUPPORT = 1'b1,
   localparam int unsigned SEL_W     = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] waddr,
   input  tset_t            wdata,
   input  logic [SEL_W-1:0] raddr,
   output tset_t            rdata
);
   tset_t entry [NUM_SETS];
   tset_t wval;

   generate
      if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
         $error("NUM_SETS must be a power of two, at least 2");
      end
      if (RZ_SUPPORT) begin : g_rz
         assign wval = wdata;
      end else begin : g_nrz_only
         assign wval = '{rz: wdata.rz & 1'b0, ret: wdata.ret, drv: wdata.drv};
      end
      for (genvar g = 0; g < NUM_SETS; g++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               entry[g] <= '0;
            else if (we && waddr == SEL_W'(g))
               entry[g] <= wval;
         end
      end
   endgenerate

   assign rdata = entry[raddr];

   // R9: a written entry reads back what was written on the next cycle
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> entry[$past(waddr)] == $past(wval));
endmodule

// File: rtl/tvf_period_seq.sv
module tvf_period_seq
   import tvf_pkg::*;
#(
   parameter int unsigned PERIOD_TICKS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OFS_W-1:0] tick,
   output logic             last
);
   localparam logic [OFS_W-1:0] LAST_TICK = OFS_W'(PERIOD_TICKS - 1);

   generate
      if (PERIOD_TICKS < 2 || PERIOD_TICKS > (1 << OFS_W)) begin : g_bad_period
         $error("PERIOD_TICKS must lie in 2 .. 2**OFS_W");
      end
   endgenerate

   assign last = (tick == LAST_TICK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick <= '0;
      else if (last)
         tick <= '0;
      else
         tick <= tick + 1'b1;
   end

   // R2: the end-of-period strobe never lasts two ticks in a row
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !last);
   // R2: the tick after the strobe restarts the period at zero
   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> tick == '0);
endmodule

// File: rtl/tvf_edge_shaper.sv
module tvf_edge_shaper
   import tvf_pkg::*;
#(
   parameter bit RZ_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OFS_W-1:0] tick,
   input  logic             last,
   input  logic             accept,
   input  logic             in_data,
   input  tset_t            in_set,
   output logic             level
);
   logic  cur_valid;
   logic  cur_data;
   tset_t cur_set;
   logic  rz_act;

   generate
      if (RZ_SUPPORT) begin : g_rz
         assign rz_act = cur_set.rz && (cur_set.ret > cur_set.drv);
      end else begin : g_nrz_only
         assign rz_act = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_valid <= 1'b0;
         cur_data  <= 1'b0;
         cur_set   <= '0;
      end else if (last) begin
         cur_valid <= accept;
         if (accept) begin
            cur_data <= in_data;
            cur_set  <= in_set;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level <= 1'b0;
      else if (cur_valid && tick == cur_set.drv)
         level <= cur_data;
      else if (cur_valid && rz_act && tick == cur_set.ret)
         level <= 1'b0;
   end

   // R6: with no vector in force the level does not move
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_valid |=> $stable(level));
   // R3: the drive edge puts the vector's data on the pin
   a_r3_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_valid && tick == cur_set.drv) |=> level == $past(cur_data));
   // R4: the return edge of an active RZ vector brings the pin to zero
   a_r4_return: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_valid && rz_act && tick == cur_set.ret) |=> !level);
endmodule

// File: rtl/tvf_channel_formatter.sv
module tvf_channel_formatter
   import tvf_pkg::*;
#(
   parameter int unsigned PERIOD_TICKS = 10,
   parameter int unsigned NUM_SETS     = 8,
   parameter bit          RZ_SUPPORT   = 1'b1,
   localparam int unsigned SEL_W       = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prog_we,
   input  logic [SEL_W-1:0] prog_addr,
   input  logic [OFS_W-1:0] prog_drv,
   input  logic [OFS_W-1:0] prog_ret,
   input  logic             prog_rz,
   input  logic             vec_valid,
   output logic             vec_ready,
   input  logic             vec_data,
   input  logic [SEL_W-1:0] vec_sel,
   output logic             pin_out
);
   logic [OFS_W-1:0] tick;
   logic             last;
   tset_t            wr_set;
   tset_t            rd_set;

   assign wr_set    = '{rz: prog_rz, ret: prog_ret, drv: prog_drv};
   assign vec_ready = last;

   tvf_timeset_rf #(.NUM_SETS(NUM_SETS), .RZ_SUPPORT(RZ_SUPPORT)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(prog_we), .waddr(prog_addr),
      .wdata(wr_set), .raddr(vec_sel), .rdata(rd_set));

   tvf_period_seq #(.PERIOD_TICKS(PERIOD_TICKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .last(last));

   tvf_edge_shaper #(.RZ_SUPPORT(RZ_SUPPORT)) u_shape (
      .clk(clk), .rst_n(rst_n), .tick(tick), .last(last),
      .accept(vec_valid && last), .in_data(vec_data), .in_set(rd_set),
      .level(pin_out));
endmodule

// File: tb/sim_tvf_channel_formatter.sv
`timescale 1ns/1ps
module sim_tvf_channel_formatter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prog_we = 1'b0;
   logic [2:0] prog_addr = '0;
   logic [3:0] prog_drv = '0;
   logic [3:0] prog_ret = '0;
   logic       prog_rz = 1'b0;
   logic       vec_valid = 1'b0;
   logic       vec_ready;
   logic       vec_data = 1'b0;
   logic [2:0] vec_sel = '0;
   logic       pin_out;

   int  total = 0;
   int  bad = 0;
   bit  done = 0;
   logic exp_level = 1'b0;

   tvf_channel_formatter u0 (.*);

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic prog(input int idx, input int drv, input int ret, input bit rz);
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 3'(idx);
      prog_drv = 4'(drv); prog_ret = 4'(ret); prog_rz = rz;
      @(negedge clk);
      prog_we = 1'b0;
   endtask

   // Offers one vector, then checks the pin after every tick of its period.
   task automatic run_vec(input bit d, input int idx, input int drv, input int ret,
                          input bit rz, input string tag, input bit rewrite = 0);
      bit act;
      act = rz && (ret > drv);
      @(negedge clk);
      while (!vec_ready) @(negedge clk);
      vec_valid = 1'b1; vec_data = d; vec_sel = 3'(idx);
      @(posedge clk);
      @(negedge clk);
      vec_valid = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (i == drv) exp_level = d;
         else if (act && i == ret) exp_level = 1'b0;
         check(pin_out === exp_level, $sformatf("%s tick%0d", tag, i),
               int'(pin_out), int'(exp_level));
         if (rewrite && i == 0) begin
            prog_we = 1'b1; prog_addr = 3'(idx); prog_drv = 4'd8;
            prog_ret = 4'd0; prog_rz = 1'b0;
         end else if (rewrite && i == 1) begin
            prog_we = 1'b0;
         end
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(pin_out === 1'b0, "R1 reset pin low", int'(pin_out), 0);
      check(vec_ready === 1'b0, "R2 ready low at tick0", int'(vec_ready), 0);
   endtask

   task automatic t_ready_rate;
      int cnt = 0;
      int first = -1;
      int second = -1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (vec_ready === 1'b1) begin
            cnt++;
            if (first < 0) first = i;
            else if (second < 0) second = i;
         end
      end
      check(cnt == 3, "R2 ready pulses in 30 ticks", cnt, 3);
      check(second - first == 10, "R2 ready spacing", second - first, 10);
      check(pin_out === 1'b0, "R6 idle after reset", int'(pin_out), 0);
   endtask

   task automatic t_idle_hold;
      logic ref_l;
      ref_l = pin_out;
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         check(pin_out === ref_l, $sformatf("R6 idle hold %0d", i),
               int'(pin_out), int'(ref_l));
      end
   endtask

   task automatic t_sweep;
      prog(5, 1, 9, 1);
      prog(6, 4, 9, 1);
      prog(7, 8, 9, 1);
      run_vec(1, 5, 1, 9, 1, "R7 sweep drv1");
      run_vec(1, 6, 4, 9, 1, "R7 sweep drv4");
      run_vec(1, 7, 8, 9, 1, "R7 sweep drv8");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ready_rate();
      run_vec(1, 7, 0, 0, 0, "R1 unwritten entry");
      prog(0, 3, 0, 0);
      prog(1, 2, 6, 1);
      prog(2, 7, 4, 1);
      prog(3, 12, 0, 0);
      prog(4, 5, 5, 1);
      run_vec(0, 0, 3, 0, 0, "R3 nrz fall");
      run_vec(1, 0, 3, 0, 0, "R3 nrz rise");
      run_vec(1, 1, 2, 6, 1, "R4 rz from high");
      run_vec(1, 1, 2, 6, 1, "R4 rz pulse");
      run_vec(1, 2, 7, 4, 1, "R5 ret before drv");
      run_vec(0, 4, 5, 5, 1, "R5 ret equals drv fall");
      run_vec(1, 4, 5, 5, 1, "R5 ret equals drv rise");
      run_vec(0, 3, 12, 0, 0, "R8 offset beyond period");
      t_idle_hold();
      t_sweep();
      run_vec(1, 0, 3, 0, 0, "R9 rewrite during vector", 1);
      run_vec(0, 0, 8, 0, 0, "R9 new timing applies");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule